// File: doc/BRIEF.md
# Two-Phase Shedding Controller

This block chooses between one-phase and two-phase operation of an interleaved converter from an unsigned power-demand word, the loop's error signal scaled to output power. When demand drops through a low threshold the second phase is dropped at once. In the same clock the remaining phase's on-time multiplier switches to double, so the power delivered stays the same and the loop sees no step. When demand climbs through a higher threshold the phase is added back in a fixed order. First the on-time is halved and the period synchronizer is asked to re-measure. Once a set number of complete periods have been measured, phase two is started at 180 degrees and two-phase operation resumes.

The gap between the two thresholds prevents chattering when demand sits near either level. A fault input from phase-fail detection forces one-phase mode. While the fault is high, adding a phase is blocked. Both thresholds, the demand width, the number of measured periods and an optional input register are parameters.

Top module: `phase_shed_ctrl`

## Requirements
- R1: While and after reset the block is in one-phase mode: ph2_en=0, ton_x2=1 (1 means on-time doubled), remeas_req=0, ph2_start=0.
- R2: From one-phase mode, a demand strictly greater than ADD_TH with fault low moves the block to the halved state on the next edge: ton_x2=0, remeas_req=1, ph2_en=0. A demand equal to ADD_TH does not.
- R3: In the halved state the block waits for MEAS_CYCLES pulses of meas_done. meas_done has no effect in any other state.
- R4: On the edge that takes the last required meas_done, the block enters a one-clock start state with ph2_en=1 and ph2_start=1. The next edge brings two-phase mode, with ph2_en=1 and ph2_start=0.
- R5: In the start state or in two-phase mode, a demand strictly less than SHED_TH returns the block to one-phase mode on the next edge. ph2_en falls and ton_x2 rises on that same edge.
- R6: A demand between SHED_TH and ADD_TH inclusive holds the current one-phase or two-phase mode. A demand equal to SHED_TH does not shed.
- R7: In the halved state, a demand strictly less than SHED_TH abandons the add sequence and returns to one-phase mode.
- R8: A high fault returns the block to one-phase mode on the next edge from any state. While fault stays high, no add sequence starts.
- R9: Shedding does not request a re-measurement: remeas_req stays 0 across a shed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| demand | input | DW | Unsigned power-demand word |
| fault | input | 1 | Phase-fail fault, level; high forces one-phase mode |
| meas_done | input | 1 | One-clock pulse per complete period measured by the synchronizer |
| ph2_en | output | 1 | Second phase enabled |
| ton_x2 | output | 1 | On-time multiplier select: 1 = doubled, 0 = nominal |
| remeas_req | output | 1 | Request to the synchronizer to re-measure the period |
| ph2_start | output | 1 | One-clock pulse: launch phase two at 180 degrees |

## Verification
The bench drives demand exactly onto each threshold and one count past it. A comparison with the wrong sense would add or shed at the boundary and lose the hysteresis band. It sends meas_done pulses while in one-phase mode and counts them in the halved state, which exposes a counter that runs outside its state or enables phase two after too few periods. Faults raised during the halved state and in two-phase mode, and then held against a high demand, catch a controller that finishes an add sequence while it should be blocked. Every shed is checked for ton_x2 and ph2_en changing on the same edge with no re-measure request.

// File: rtl/phsh_pkg.sv
package phsh_pkg;
   typedef enum logic [1:0] {
      ST_SINGLE   = 2'd0,
      ST_HALVED   = 2'd1,
      ST_MEASURED = 2'd2,
      ST_DUAL     = 2'd3
   } phsh_state_e;
endpackage

// File: rtl/phsh_demand_cmp.sv
module phsh_demand_cmp #(
   parameter int DW     = 8,
   parameter int SHED_TH = 77,
   parameter int ADD_TH  = 102,
   parameter bit IN_REG  = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] demand,
   output logic          add_req,
   output logic          shed_req
);
   localparam logic [DW-1:0] SHED_V = DW'(SHED_TH);
   localparam logic [DW-1:0] ADD_V  = DW'(ADD_TH);

   logic [DW-1:0] dem_s;

   generate
      if (IN_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dem_s <= '0;
            else        dem_s <= demand;
         end
      end else begin : g_comb
         always_comb dem_s = demand;
      end
   endgenerate

   always_comb begin
      add_req  = (dem_s > ADD_V);
      shed_req = (dem_s < SHED_V);
   end

   // R6: the two requests are never both active, since the band is non-empty
   always_comb begin
      assert_req_exclusive_R6: assert (!(add_req && shed_req));
   end
endmodule

// File: rtl/phsh_meas_count.sv
module phsh_meas_count #(
   parameter int MEAS_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic done
);
   localparam int CW = (MEAS_CYCLES < 2) ? 1 : $clog2(MEAS_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(MEAS_CYCLES - 1);

   logic [CW-1:0] cnt;

   always_comb done = tick && !clr && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr || done)       cnt <= '0;
      else if (tick)              cnt <= cnt + 1'b1;
   end

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
   assert_clr_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
endmodule

// File: rtl/phase_shed_ctrl.sv
module phase_shed_ctrl #(
   parameter int DW          = 8,
   parameter int SHED_TH     = 77,
   parameter int ADD_TH      = 102,
   parameter int MEAS_CYCLES = 2,
   parameter bit IN_REG      = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] demand,
   input  logic          fault,
   input  logic          meas_done,
   output logic          ph2_en,
   output logic          ton_x2,
   output logic          remeas_req,
   output logic          ph2_start
);
   import phsh_pkg::*;

   initial begin
      if (DW < 2 || DW > 32) $error("phase_shed_ctrl: DW out of range");
      if (SHED_TH < 1 || SHED_TH >= ADD_TH) $error("phase_shed_ctrl: need 0 < SHED_TH < ADD_TH");
      if (ADD_TH >= (64'd1 << DW) - 1) $error("phase_shed_ctrl: ADD_TH leaves no add range");
      if (MEAS_CYCLES < 1) $error("phase_shed_ctrl: MEAS_CYCLES must be at least 1");
   end

   phsh_state_e state, nxt;
   logic        add_req, shed_req, meas_ok, cnt_clr;

   phsh_demand_cmp #(
      .DW(DW), .SHED_TH(SHED_TH), .ADD_TH(ADD_TH), .IN_REG(IN_REG)
   ) u_cmp (
      .clk(clk), .rst_n(rst_n), .demand(demand),
      .add_req(add_req), .shed_req(shed_req)
   );

   always_comb cnt_clr = (state != ST_HALVED);

   phsh_meas_count #(.MEAS_CYCLES(MEAS_CYCLES)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(meas_done), .done(meas_ok)
   );

   always_comb begin
      nxt = state;
      if (fault) begin
         nxt = ST_SINGLE;
      end else begin
         unique case (state)
            ST_SINGLE:   if (add_req)       nxt = ST_HALVED;
            ST_HALVED:   if (shed_req)      nxt = ST_SINGLE;
                         else if (meas_ok)  nxt = ST_MEASURED;
            ST_MEASURED: if (shed_req)      nxt = ST_SINGLE;
                         else               nxt = ST_DUAL;
            ST_DUAL:     if (shed_req)      nxt = ST_SINGLE;
            default:                        nxt = ST_SINGLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_SINGLE;
      else        state <= nxt;
   end

   always_comb begin
      ph2_en     = (state == ST_MEASURED) || (state == ST_DUAL);
      ton_x2     = (state == ST_SINGLE);
      remeas_req = (state == ST_HALVED);
      ph2_start  = (state == ST_MEASURED);
   end

   assert_add_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ton_x2) |-> ($past(add_req) && !$past(fault)));
   assert_start_after_meas_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ph2_en) |-> $past(remeas_req) && $past(meas_done));
   assert_start_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ph2_start |=> !ph2_start);
   assert_shed_atomic_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ph2_en) |-> $rose(ton_x2));
   assert_band_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ph2_en && !shed_req && !fault) |=> ph2_en);
   assert_fault_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (ton_x2 && !ph2_en && !remeas_req));
   assert_shed_no_remeas_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ph2_en) |-> !remeas_req);
endmodule

// File: tb/sim_phase_shed_ctrl.sv
module sim_phase_shed_ctrl;
   localparam int DW = 8;

   typedef struct packed {
      logic ph2, x2, rq, st;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] demand = '0;
   logic          fault = 1'b0;
   logic          meas_done = 1'b0;
   logic          ph2_en, ton_x2, remeas_req, ph2_start;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   exp_t  q_exp[$];
   string q_tag[$];

   always #2.5 clk = ~clk;

   phase_shed_ctrl #(.DW(DW), .SHED_TH(77), .ADD_TH(102), .MEAS_CYCLES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .demand(demand), .fault(fault),
      .meas_done(meas_done), .ph2_en(ph2_en), .ton_x2(ton_x2),
      .remeas_req(remeas_req), .ph2_start(ph2_start)
   );

   task automatic compare(input exp_t e, input string tag);
      exp_t a;
      a = '{ph2: ph2_en, x2: ton_x2, rq: remeas_req, st: ph2_start};
      compared++;
      if (a !== e) begin
         mismatched++;
         $display("FAIL %s: got ph2/x2/rq/st=%b expected %b", tag, a, e);
      end
   endtask

   // driver: apply inputs at negedge, queue the outputs expected after the next edge
   task automatic step(input int dem, input bit flt, input bit md,
                       input exp_t e, input string tag);
      @(negedge clk);
      demand    = DW'(dem);
      fault     = flt;
      meas_done = md;
      q_exp.push_back(e);
      q_tag.push_back(tag);
   endtask

   // monitor: sample 1 ns after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q_exp.size() > 0) compare(q_exp.pop_front(), q_tag.pop_front());
      end
   end

   localparam exp_t SGL = '{ph2:1'b0, x2:1'b1, rq:1'b0, st:1'b0};
   localparam exp_t HLV = '{ph2:1'b0, x2:1'b0, rq:1'b1, st:1'b0};
   localparam exp_t MSR = '{ph2:1'b1, x2:1'b0, rq:1'b0, st:1'b1};
   localparam exp_t DUA = '{ph2:1'b1, x2:1'b0, rq:1'b0, st:1'b0};

   initial begin
      repeat (3) @(posedge clk);
      #1 compare(SGL, "R1 in reset");
      @(negedge clk) rst_n = 1'b1;
      step( 50, 0, 0, SGL, "R1 after reset");
      step( 50, 0, 1, SGL, "R3 meas_done ignored in single");
      step(102, 0, 0, SGL, "R2/R6 demand equal ADD_TH holds");
      step(103, 0, 0, HLV, "R2 add starts halved");
      step(103, 0, 0, HLV, "R3 waiting without pulses");
      step(103, 0, 1, HLV, "R3 first period measured");
      step(103, 0, 1, MSR, "R4 start pulse after last period");
      step(103, 0, 0, DUA, "R4 two-phase");
      step( 90, 0, 0, DUA, "R6 band holds two-phase");
      step( 77, 0, 0, DUA, "R6 demand equal SHED_TH holds");
      step( 76, 0, 0, SGL, "R5/R9 shed doubles on-time same edge");
      step( 90, 0, 1, SGL, "R6 band holds single");
      step(200, 0, 0, HLV, "R2 add again");
      step(200, 0, 1, HLV, "R3 one period");
      step( 50, 0, 0, SGL, "R7 abort add on low demand");
      step(200, 1, 0, SGL, "R8 fault blocks add");
      step(200, 1, 1, SGL, "R8 fault still blocks");
      step(200, 0, 0, HLV, "R8 cleared allows add");
      step(200, 1, 1, SGL, "R8 fault in halved");
      step(200, 0, 0, HLV, "R2 re-add after fault");
      step(200, 0, 1, HLV, "R3 count restarted");
      step(200, 0, 1, MSR, "R4 start");
      step(200, 1, 0, SGL, "R8 fault in two-phase path");
      step(200, 0, 0, HLV, "R2 add");
      step(200, 0, 1, HLV, "R3 one");
      step(200, 0, 1, MSR, "R4 start");
      step( 10, 0, 0, SGL, "R5 shed from start state");
      step(200, 0, 0, HLV, "R2 add");
      step(200, 0, 1, HLV, "R3 one");
      step(200, 0, 1, MSR, "R4 start");
      step(200, 0, 0, DUA, "R4 dual");
      step(200, 1, 0, SGL, "R8/R9 fault shed from dual");
      step(200, 1, 0, SGL, "R8 held");
      @(negedge clk);
      @(negedge clk);
      finished = 1'b1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (2000) @(posedge clk);
            mismatched++;
            compared++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule